// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column addresses of one SDRAM read or write burst, one column per enabled clock. A command stage pulses `start` with the first column of the access and tells the block whether the access is a write. The block takes the burst settings from the mode fields held elsewhere: length code, ordering type and the write-single flag. It then steps through the burst. Each beat gives a registered column, a valid flag and a flag that marks the final beat of a fixed-length burst.

Fixed bursts of 1, 2, 4 or 8 beats wrap inside the aligned block of columns that holds the start column. The order within that block is either sequential or interleaved. A full-row burst counts up through the whole row and wraps at the row end. It runs until a terminate request or a new access stops it. When the write-single flag is set, every write is one beat long and reads keep the programmed length. A length code that has no meaning, or a full-row request with interleaved ordering, still produces a defined burst and raises an error flag. A new access may arrive on any enabled clock and replaces the burst in progress. When the clock enable is low, the block holds all of its state.

Top module: `sdr_burst_seq`

## Requirements
- R1: After a synchronous reset, `col_valid`, `col_last` and `mode_err` are 0 and `col_out` is 0.
- R2: A `start` sampled with `ce` high makes `col_valid` 1 and `col_out` equal to `start_col` after that edge.
- R3: `len_code` 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 beats. 3'b111 gives a full-row burst.
- R4: In a fixed sequential burst of length BL (`interleave`=0), the column bits above log2(BL) stay equal to the start column. The low bits equal (start + beat) mod BL.
- R5: In a fixed interleaved burst (`interleave`=1), the low log2(BL) bits equal the start's low bits XOR the beat index. The upper bits stay fixed.
- R6: A full-row burst increments the column by one each beat, wrapping modulo 2^COL_W. It never asserts `col_last` and continues until a terminate or a new start.
- R7: `col_last` is 1 exactly on the final beat of a fixed burst. On the next enabled edge without a start, `col_valid` goes to 0.
- R8: When `wr_single`=1 and `start_wr`=1, the burst is one beat whatever `len_code` says. With `start_wr`=0, the programmed length and order apply.
- R9: Codes 3'b100, 3'b101 and 3'b110 run as a one-beat burst. Full row with `interleave`=1 runs as sequential full row. Both cases set `mode_err` for that burst, and a legal start clears it.
- R10: `term` sampled with `ce` high and no `start` drops `col_valid` and `col_last` after that edge.
- R11: A `start` during a burst replaces it on the same edge. It takes priority over a simultaneous `term`.
- R12: While `ce` is 0, `col_out`, `col_valid`, `col_last` and `mode_err` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable; all state advances only when high |
| start | input | 1 | New read or write access |
| start_wr | input | 1 | 1 when the access is a write |
| start_col | input | COL_W | First column of the access |
| len_code | input | 3 | Programmed burst length code |
| interleave | input | 1 | 1 selects interleaved ordering |
| wr_single | input | 1 | 1 makes every write a single beat |
| term | input | 1 | Ends the current burst |
| col_out | output | COL_W | Column of the current beat |
| col_valid | output | 1 | Current beat is valid |
| col_last | output | 1 | Current beat is the final one of a fixed burst |
| mode_err | output | 1 | Current burst came from an illegal setting |

## Verification
The hardest case to reach is a full-row burst crossing the top of the row. Stimulus reaches it by starting two columns below the row end and letting the burst run past it until it wraps to column zero. A terminate then stops the burst. The second hard case is a restart that lands mid-burst at the same edge as a terminate. The bench raises both inputs on one enabled edge, in the middle of an eight-beat burst, and checks that the new burst wins. A third case is a clock-enable stall in the middle of a burst. The bench holds `ce` low across several edges and then confirms that the order resumes where it left off.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

  // Largest fixed burst is 8 beats: 3 bits of beat index.
  localparam int MAX_LOG = 3;
  localparam int CNT_W   = MAX_LOG;

  typedef enum logic [2:0] {
    LEN_1   = 3'b000,
    LEN_2   = 3'b001,
    LEN_4   = 3'b010,
    LEN_8   = 3'b011,
    LEN_ROW = 3'b111
  } len_code_e;

  typedef struct packed {
    logic [1:0] len_log;  // log2 of fixed length
    logic       full;     // full-row continuous
    logic       inter;    // interleaved order
    logic       err;      // illegal setting seen
  } burst_cfg_t;

endpackage

// File: rtl/sdr_burst_mode_dec.sv
module sdr_burst_mode_dec
  import sdr_burst_pkg::*;
(
  input  logic [2:0] len_code,
  input  logic       interleave,
  input  logic       wr_single,
  input  logic       is_write,
  output burst_cfg_t cfg
);

  always_comb begin
    cfg = '0;
    if (wr_single && is_write) begin
      // length field ignored for writes in this mode
      cfg.len_log = 2'd0;
    end else begin
      unique case (len_code)
        LEN_1:   cfg.len_log = 2'd0;
        LEN_2:   begin cfg.len_log = 2'd1; cfg.inter = interleave; end
        LEN_4:   begin cfg.len_log = 2'd2; cfg.inter = interleave; end
        LEN_8:   begin cfg.len_log = 2'd3; cfg.inter = interleave; end
        LEN_ROW: begin
          cfg.full = 1'b1;
          cfg.err  = interleave;  // falls back to sequential
        end
        default: begin
          cfg.len_log = 2'd0;
          cfg.err     = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/sdr_burst_colgen.sv
module sdr_burst_colgen
  import sdr_burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] cur_col,
  input  logic [CNT_W-1:0] beat,
  input  logic [1:0]       len_log,
  input  logic             inter,
  input  logic             full,
  output logic [COL_W-1:0] next_col
);

  logic [CNT_W-1:0] off_seq;
  logic [CNT_W-1:0] off_int;
  logic [CNT_W-1:0] off_sel;
  logic [COL_W-1:0] fixed_col;

  assign off_seq = base[CNT_W-1:0] + beat;
  assign off_int = base[CNT_W-1:0] ^ beat;
  assign off_sel = inter ? off_int : off_seq;

  // Per bit: inside the burst block take the offset, above it keep the start.
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    if (i < CNT_W) begin : g_low
      assign fixed_col[i] = (i < int'(len_log)) ? off_sel[i] : base[i];
    end else begin : g_high
      assign fixed_col[i] = base[i];
    end
  end

  assign next_col = full ? (cur_col + COL_W'(1)) : fixed_col;

endmodule

// File: rtl/sdr_burst_ctrl.sv
module sdr_burst_ctrl
  import sdr_burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             term,
  input  burst_cfg_t       cfg,
  input  logic [COL_W-1:0] next_col,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] col_q,
  output logic [CNT_W-1:0] beat_nxt,
  output logic [1:0]       len_log_q,
  output logic             inter_q,
  output logic             full_q,
  output logic             valid_q,
  output logic             last_q,
  output logic             err_q
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_m1;

  assign beat_nxt = cnt_q + CNT_W'(1);
  assign len_m1   = CNT_W'((32'd1 << len_log_q) - 32'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      col_q     <= '0;
      cnt_q     <= '0;
      len_log_q <= '0;
      inter_q   <= 1'b0;
      full_q    <= 1'b0;
      valid_q   <= 1'b0;
      last_q    <= 1'b0;
      err_q     <= 1'b0;
    end else if (ce) begin
      if (start) begin
        base_q    <= start_col;
        col_q     <= start_col;
        cnt_q     <= '0;
        len_log_q <= cfg.len_log;
        inter_q   <= cfg.inter;
        full_q    <= cfg.full;
        err_q     <= cfg.err;
        valid_q   <= 1'b1;
        last_q    <= !cfg.full && (cfg.len_log == 2'd0);
      end else if (term) begin
        valid_q <= 1'b0;
        last_q  <= 1'b0;
      end else if (valid_q) begin
        if (last_q) begin
          valid_q <= 1'b0;
          last_q  <= 1'b0;
        end else begin
          cnt_q  <= beat_nxt;
          col_q  <= next_col;
          last_q <= !full_q && (beat_nxt == len_m1);
        end
      end
    end
  end

  // R12: a low enable freezes the outputs
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(col_q) && $stable(valid_q) && $stable(last_q) && $stable(err_q)));

  // R2: start loads the first column
  a_r2_start_load: assert property (@(posedge clk) disable iff (rst)
    (ce && start) |=> (valid_q && col_q == $past(start_col)));

  // R10: terminate without start ends the burst
  a_r10_term_stops: assert property (@(posedge clk) disable iff (rst)
    (ce && term && !start) |=> !valid_q);

  // R7: final beat is followed by idle
  a_r7_last_ends: assert property (@(posedge clk) disable iff (rst)
    (ce && !start && last_q) |=> !valid_q);

  // R7: a final-beat mark only on a valid beat
  a_r7_last_valid: assert property (@(posedge clk) disable iff (rst)
    last_q |-> valid_q);

  // R6: full-row beats step by one and never mark a last beat
  a_r6_row_step: assert property (@(posedge clk) disable iff (rst)
    (ce && !start && !term && valid_q && full_q) |=>
      (col_q == $past(col_q) + COL_W'(1) && !last_q));

  // R4: fixed bursts keep the bits above the burst block
  a_r4_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !full_q) |-> ((col_q >> len_log_q) == (base_q >> len_log_q)));

endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
  import sdr_burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             start,
  input  logic             start_wr,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             interleave,
  input  logic             wr_single,
  input  logic             term,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             col_last,
  output logic             mode_err
);

  burst_cfg_t       cfg;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] col_q;
  logic [COL_W-1:0] next_col;
  logic [CNT_W-1:0] beat_nxt;
  logic [1:0]       len_log_q;
  logic             inter_q;
  logic             full_q;

  sdr_burst_mode_dec u_dec (
    .len_code   (len_code),
    .interleave (interleave),
    .wr_single  (wr_single),
    .is_write   (start_wr),
    .cfg        (cfg)
  );

  sdr_burst_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ce        (ce),
    .start     (start),
    .start_col (start_col),
    .term      (term),
    .cfg       (cfg),
    .next_col  (next_col),
    .base_q    (base_q),
    .col_q     (col_q),
    .beat_nxt  (beat_nxt),
    .len_log_q (len_log_q),
    .inter_q   (inter_q),
    .full_q    (full_q),
    .valid_q   (col_valid),
    .last_q    (col_last),
    .err_q     (mode_err)
  );

  sdr_burst_colgen #(.COL_W(COL_W)) u_gen (
    .base     (base_q),
    .cur_col  (col_q),
    .beat     (beat_nxt),
    .len_log  (len_log_q),
    .inter    (inter_q),
    .full     (full_q),
    .next_col (next_col)
  );

  assign col_out = col_q;

endmodule

// File: tb/sim_sdr_burst_seq.sv
module sim_sdr_burst_seq;

  localparam int COL_W = 10;
  localparam int ROW   = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ce = 1'b1;
  logic             start = 1'b0;
  logic             start_wr = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       len_code = 3'b000;
  logic             interleave = 1'b0;
  logic             wr_single = 1'b0;
  logic             term = 1'b0;
  logic [COL_W-1:0] col_out;
  logic             col_valid;
  logic             col_last;
  logic             mode_err;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sdr_burst_seq #(.COL_W(COL_W)) u0 (
    .clk(clk), .rst(rst), .ce(ce), .start(start), .start_wr(start_wr),
    .start_col(start_col), .len_code(len_code), .interleave(interleave),
    .wr_single(wr_single), .term(term), .col_out(col_out),
    .col_valid(col_valid), .col_last(col_last), .mode_err(mode_err)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int model(int base, int bl, bit inter, bit full, int k);
    int m;
    if (full) return (base + k) % ROW;
    m = bl - 1;
    if (inter) return (base & ~m) | ((base ^ k) & m);
    return (base & ~m) | ((base + k) & m);
  endfunction

  task automatic issue(int col, logic [2:0] lc, bit il, bit ws, bit wr);
    start_col  = COL_W'(col);
    len_code   = lc;
    interleave = il;
    wr_single  = ws;
    start_wr   = wr;
    start      = 1'b1;
    @(negedge clk);
    start      = 1'b0;
  endtask

  // Runs a whole burst and checks every beat.
  task automatic run_burst(string req, int col, logic [2:0] lc, bit il, bit ws,
                           bit wr, int nbeats, int bl, bit inter, bit full, bit err);
    issue(col, lc, il, ws, wr);
    chk(req, "err", mode_err, err);
    for (int k = 0; k < nbeats; k++) begin
      chk(req, "col", col_out, model(col, bl, inter, full, k));
      chk(req, "valid", col_valid, 1);
      chk(req, "last", col_last, (!full && k == nbeats - 1) ? 1 : 0);
      if (full && k == nbeats - 1) term = 1'b1;
      @(negedge clk);
    end
    term = 1'b0;
    chk(req, "valid after end", col_valid, 0);
  endtask

  task automatic t_reset();
    chk("R1", "valid", col_valid, 0);
    chk("R1", "last", col_last, 0);
    chk("R1", "err", mode_err, 0);
    chk("R1", "col", col_out, 0);
  endtask

  task automatic t_lengths();
    run_burst("R3_R2 len1", 37, 3'b000, 0, 0, 0, 1, 1, 0, 0, 0);
    run_burst("R3_R4 seq2", 5, 3'b001, 0, 0, 0, 2, 2, 0, 0, 0);
    run_burst("R3_R4 seq4", 14, 3'b010, 0, 0, 0, 4, 4, 0, 0, 0);
    run_burst("R3_R4 seq8", 101, 3'b011, 0, 0, 0, 8, 8, 0, 0, 0);
    run_burst("R5 int4", 22, 3'b010, 1, 0, 0, 4, 4, 1, 0, 0);
    run_burst("R5 int8", 205, 3'b011, 1, 0, 0, 8, 8, 1, 0, 0);
    run_burst("R5 int2", 9, 3'b001, 1, 0, 0, 2, 2, 1, 0, 0);
  endtask

  task automatic t_full_row();
    // crosses the row end: 1022, 1023, 0, 1, 2
    run_burst("R6 row wrap", ROW - 2, 3'b111, 0, 0, 0, 5, 1, 0, 1, 0);
  endtask

  task automatic t_write_single();
    run_burst("R8 write", 50, 3'b011, 0, 1, 1, 1, 1, 0, 0, 0);
    run_burst("R8 read", 50, 3'b011, 0, 1, 0, 8, 8, 0, 0, 0);
  endtask

  task automatic t_illegal();
    run_burst("R9 code101", 77, 3'b101, 0, 0, 0, 1, 1, 0, 0, 1);
    run_burst("R9 code110", 78, 3'b110, 1, 0, 0, 1, 1, 0, 0, 1);
    run_burst("R9 int row", 300, 3'b111, 1, 0, 0, 4, 1, 0, 1, 1);
    run_burst("R9 clear", 16, 3'b010, 0, 0, 0, 4, 4, 0, 0, 0);
  endtask

  task automatic t_stall();
    issue(3, 3'b011, 0, 0, 0);
    chk("R12", "beat0", col_out, model(3, 8, 0, 0, 0));
    ce = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R12", "held col", col_out, model(3, 8, 0, 0, 0));
      chk("R12", "held valid", col_valid, 1);
    end
    ce = 1'b1;
    @(negedge clk);
    chk("R12", "resume beat1", col_out, model(3, 8, 0, 0, 1));
    @(negedge clk);
    chk("R12", "resume beat2", col_out, model(3, 8, 0, 0, 2));
    term = 1'b1;
    @(negedge clk);
    term = 1'b0;
    chk("R10", "valid after term", col_valid, 0);
    chk("R10", "last after term", col_last, 0);
  endtask

  task automatic t_replace();
    issue(8, 3'b011, 0, 0, 0);
    @(negedge clk);
    chk("R11", "old beat1", col_out, 9);
    term = 1'b1;
    issue(42, 3'b010, 1, 0, 0);
    term = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R11", "new col", col_out, model(42, 4, 1, 0, k));
      chk("R11", "new last", col_last, (k == 3) ? 1 : 0);
      @(negedge clk);
    end
    chk("R7", "idle after last", col_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_lengths();
    t_full_row();
    t_write_single();
    t_illegal();
    t_stall();
    t_replace();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule